// File: doc/BRIEF.md
# Two-Dice Game Controller

This block referees a two-dice game. A die generator outside the block advances while the roll button is held, and the block drives that generator's count enable. When the player lets go of the button, the block reads the two die faces, adds them and decides the roll. The first roll of a game follows one set of rules. Later rolls are compared against a point that the first roll captured.

A game ends in a win or a loss. Each of these is held on its own output until reset. Reset is asynchronous on assertion and is released in step with the clock. It clears the outcome and the stored point, and it returns the controller to the first roll. The block expects a debounced button and die faces in the range 1 to 6.

Top module: `dice_ctrl`

## Requirements
- R1: On the first roll, a sum of 7 or 11 sets `win` one clock after the cycle in which `roll_btn` is seen low after being high.
- R2: On the first roll, a sum of 2, 3 or 12 sets `lose` one clock after the release cycle.
- R3: On the first roll, any other sum raises `pt_store` for exactly the release cycle, with `win` and `lose` low. It stores the sum as the point, and the game continues.
- R4: On a later roll, a sum equal to the stored point sets `win` one clock after the release cycle.
- R5: On a later roll, a sum of 7 sets `lose`. Any other sum that does not match the point leaves both outcomes low and needs another roll.
- R6: The point is written only by the first roll of a game. On later rolls `pt_store` stays low and the comparison uses the first-roll sum.
- R7: `cnt_en` follows `roll_btn` while the game is undecided, and it is 0 once `win` or `lose` is high.
- R8: A roll is evaluated only at release, with the die values present in the release cycle. A long press counts as one roll, and die values seen while the button is held have no effect.
- R9: `win` and `lose` are sticky. Pressing and releasing the button after the game ends changes neither output and raises no `pt_store`.
- R10: Driving `rst_n` low clears `win` and `lose` at once, without waiting for a clock. After release, a new game starts at the first roll.
- R11: `win` and `lose` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| roll_btn | input | 1 | Debounced roll button, 1 = pressed |
| die_a | input | 3 | First die face, 1 to 6 |
| die_b | input | 3 | Second die face, 1 to 6 |
| cnt_en | output | 1 | Enable for the external die generator |
| pt_store | output | 1 | Strobe that loads the sum into the point register |
| win | output | 1 | Game won, held until reset |
| lose | output | 1 | Game lost, held until reset |

## Verification
The release cycle carries two things at once: the counter enable drops, and the roll decision is taken, either as a store strobe or as the next-state change into win or lose. The bench drops the button on a falling clock edge with chosen dice. In that same half cycle it captures `pt_store` and `cnt_en`, and on the next one it captures `win` and `lose`. A scoreboard then compares both captures against the outcome it predicted from the game rules. Presses after the game is over, and long holds with changing dice, are decided by the same scoreboard, so any stray store or outcome change shows up as a mismatch.

// File: rtl/dice_pkg.sv
package dice_pkg;
  parameter int unsigned DIE_W = 3;
  parameter int unsigned SUM_W = 4;

  typedef enum logic [2:0] {
    ST_FIRST = 3'd0,
    ST_WAIT  = 3'd1,
    ST_NEXT  = 3'd2,
    ST_WIN   = 3'd3,
    ST_LOSE  = 3'd4
  } game_st_e;
endpackage

// File: rtl/dice_rst_sync.sv
module dice_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dice_sum_eval.sv
module dice_sum_eval #(
  parameter int unsigned DIE_W = 3,
  parameter int unsigned SUM_W = 4
) (
  input  logic [DIE_W-1:0] die_a,
  input  logic [DIE_W-1:0] die_b,
  input  logic [SUM_W-1:0] point,
  output logic [SUM_W-1:0] sum,
  output logic             is_seven,
  output logic             is_natural,
  output logic             is_craps,
  output logic             eq_point
);
  localparam logic [SUM_W-1:0] K2  = SUM_W'(2);
  localparam logic [SUM_W-1:0] K3  = SUM_W'(3);
  localparam logic [SUM_W-1:0] K7  = SUM_W'(7);
  localparam logic [SUM_W-1:0] K11 = SUM_W'(11);
  localparam logic [SUM_W-1:0] K12 = SUM_W'(12);

  always_comb begin
    sum        = SUM_W'(die_a) + SUM_W'(die_b);
    is_seven   = (sum == K7);
    is_natural = (sum == K7) || (sum == K11);
    is_craps   = (sum == K2) || (sum == K3) || (sum == K12);
    eq_point   = (point != '0) && (sum == point);
  end

  // R5: a seven is always among the natural sums and never craps
  always_comb begin
    if (is_seven) begin
      a_seven_natural_r5: assert (is_natural && !is_craps);
    end
  end
endmodule

// File: rtl/dice_point_reg.sv
module dice_point_reg #(
  parameter int unsigned SUM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SUM_W-1:0] d,
  output logic [SUM_W-1:0] q
);
  logic [SUM_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_point_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/dice_fsm.sv
module dice_fsm
  import dice_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  input  logic is_seven,
  input  logic is_natural,
  input  logic is_craps,
  input  logic eq_point,
  output logic cnt_en,
  output logic pt_store,
  output logic win,
  output logic lose
);
  game_st_e state, state_nxt;
  logic     btn_q;
  logic     release_w;

  assign release_w = btn_q && !btn;

  always_comb begin
    state_nxt = state;
    pt_store  = 1'b0;
    case (state)
      ST_FIRST: if (release_w) begin
        if (is_natural)    state_nxt = ST_WIN;
        else if (is_craps) state_nxt = ST_LOSE;
        else begin
          state_nxt = ST_WAIT;
          pt_store  = 1'b1;
        end
      end
      ST_WAIT: if (btn) state_nxt = ST_NEXT;
      ST_NEXT: if (release_w) begin
        if (eq_point)      state_nxt = ST_WIN;
        else if (is_seven) state_nxt = ST_LOSE;
        else               state_nxt = ST_WAIT;
      end
      ST_WIN:  state_nxt = ST_WIN;
      ST_LOSE: state_nxt = ST_LOSE;
      default: state_nxt = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FIRST;
      btn_q <= 1'b0;
    end else begin
      state <= state_nxt;
      btn_q <= btn;
    end
  end

  assign win    = (state == ST_WIN);
  assign lose   = (state == ST_LOSE);
  assign cnt_en = btn && !win && !lose;

  p_win_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win |=> win);
  p_lose_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lose |=> lose);
  p_store_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_store |=> (!pt_store && !win && !lose));
  p_no_eval_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIRST && btn) |=> (!win && !lose));
endmodule

// File: rtl/dice_ctrl.sv
module dice_ctrl
  import dice_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             roll_btn,
  input  logic [DIE_W-1:0] die_a,
  input  logic [DIE_W-1:0] die_b,
  output logic             cnt_en,
  output logic             pt_store,
  output logic             win,
  output logic             lose
);
  logic             rst_i_n;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] point;
  logic             is_seven, is_natural, is_craps, eq_point;

  dice_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_i_n)
  );

  dice_sum_eval #(.DIE_W(DIE_W), .SUM_W(SUM_W)) i_sum_eval (
    .die_a(die_a), .die_b(die_b), .point(point), .sum(sum),
    .is_seven(is_seven), .is_natural(is_natural), .is_craps(is_craps),
    .eq_point(eq_point)
  );

  dice_point_reg #(.SUM_W(SUM_W)) i_point_reg (
    .clk(clk), .rst_n(rst_i_n), .load(pt_store), .d(sum), .q(point)
  );

  dice_fsm i_fsm (
    .clk(clk), .rst_n(rst_i_n), .btn(roll_btn),
    .is_seven(is_seven), .is_natural(is_natural), .is_craps(is_craps),
    .eq_point(eq_point), .cnt_en(cnt_en), .pt_store(pt_store),
    .win(win), .lose(lose)
  );

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(win && lose));
  p_cnt_off_done_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (win || lose) |-> !cnt_en);
endmodule

// File: tb/test_dice_ctrl.sv
module test_dice_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       roll_btn;
  logic [2:0] die_a, die_b;
  logic       cnt_en, pt_store, win, lose;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  w;
    logic  l;
    logic  s;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // bench game model
  bit       m_done, m_win, m_lose, m_later;
  int       m_point;
  bit       mon_skip = 1'b1;
  bit       btn_prev = 1'b0;
  bit       pend = 1'b0;
  logic     cap_s, cap_c;

  always #4 clk = ~clk;

  dice_ctrl i_dice_ctrl (
    .clk(clk), .rst_n(rst_n), .roll_btn(roll_btn), .die_a(die_a),
    .die_b(die_b), .cnt_en(cnt_en), .pt_store(pt_store), .win(win),
    .lose(lose)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic do_reset();
    mon_skip = 1'b1;
    @(negedge clk);
    roll_btn = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk(win == 1'b0, "R10 win cleared async", win, 0);
    chk(lose == 1'b0, "R10 lose cleared async", lose, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_done = 0; m_win = 0; m_lose = 0; m_later = 0; m_point = 0;
    pend = 1'b0;
    btn_prev = 1'b0;
    mon_skip = 1'b0;
  endtask

  // driver: press, hold with changing dice, release with chosen dice
  task automatic roll(input int a, input int b, input int hold, input string tag);
    exp_t e;
    int   s;
    @(negedge clk);
    roll_btn = 1'b1;
    for (int i = 0; i < hold; i++) begin
      die_a = 3'(1 + (i % 6));
      die_b = 3'(6 - (i % 6));
      @(negedge clk);
      #2;
      chk(cnt_en == !m_done, "R7 cnt_en while held", cnt_en, !m_done);
    end
    @(negedge clk);
    die_a = 3'(a);
    die_b = 3'(b);
    roll_btn = 1'b0;
    s = a + b;
    e.tag = tag;
    e.s = 1'b0;
    if (!m_done) begin
      if (!m_later) begin
        if (s == 7 || s == 11)             m_win = 1;
        else if (s == 2 || s == 3 || s == 12) m_lose = 1;
        else begin e.s = 1'b1; m_point = s; m_later = 1; end
      end else begin
        if (s == m_point)  m_win = 1;
        else if (s == 7)   m_lose = 1;
      end
      m_done = m_win || m_lose;
    end
    e.w = m_win;
    e.l = m_lose;
    sb_q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  // monitor: capture release cycle, then outcome one clock later
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (!mon_skip) begin
      if (btn_prev && !roll_btn) begin
        cap_s = pt_store;
        cap_c = cnt_en;
        pend  = 1'b1;
      end else if (pend) begin
        pend = 1'b0;
        if (sb_q.size() == 0) begin
          chk(1'b0, "scoreboard empty", 0, 1);
        end else begin
          e = sb_q.pop_front();
          chk(win == e.w, {e.tag, " win"}, win, e.w);
          chk(lose == e.l, {e.tag, " lose"}, lose, e.l);
          chk(cap_s == e.s, {e.tag, " pt_store"}, cap_s, e.s);
          chk(cap_c == 1'b0, "R7 cnt_en low at release", cap_c, 0);
          chk(!(win && lose), "R11 single outcome", win + lose, 1);
        end
      end
    end
    btn_prev = roll_btn;
  end

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    roll_btn = 1'b0;
    die_a = 3'd1;
    die_b = 3'd1;
    repeat (3) @(negedge clk);
    #2;
    chk(win == 0 && lose == 0, "R10 reset outcome", win + lose, 0);
    chk(cnt_en == 0 && pt_store == 0, "R10 reset strobes", cnt_en + pt_store, 0);
    do_reset();

    roll(3, 4, 2, "R1 first 7");
    roll(2, 2, 3, "R9 press after win");
    roll(6, 6, 1, "R9 second press after win");
    do_reset();
    roll(5, 6, 2, "R1 first 11");
    do_reset();
    roll(1, 1, 2, "R2 first 2");
    roll(3, 4, 2, "R9 press after loss");
    do_reset();
    roll(1, 2, 1, "R2 first 3");
    do_reset();
    roll(6, 6, 2, "R2 first 12");
    do_reset();
    roll(2, 4, 2, "R3 first 6 stores point");
    roll(4, 4, 2, "R5 later 8 continues");
    roll(5, 5, 1, "R6 later 10 no store");
    roll(2, 5, 2, "R5 later 7 loses");
    do_reset();
    roll(3, 5, 2, "R3 first 8 stores point");
    roll(3, 3, 2, "R6 later 6 continues");
    roll(6, 2, 2, "R4 later matches point");
    do_reset();
    roll(3, 4, 20, "R8 long hold one roll");
    do_reset();
    roll(1, 3, 15, "R8 long hold first 4");
    roll(2, 2, 2, "R4 later 4 wins");
    do_reset();
    roll(4, 5, 2, "R3 first 9");
    roll(6, 6, 2, "R5 later 12 continues");
    roll(4, 3, 2, "R5 later 7 after continue");

    // reset asserted while a roll is held
    do_reset();
    roll(2, 3, 2, "R3 first 5");
    mon_skip = 1'b1;
    @(negedge clk);
    roll_btn = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    chk(win == 0 && lose == 0, "R10 async reset mid hold", win + lose, 0);
    @(negedge clk);
    roll_btn = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(win == 0 && lose == 0, "R10 first roll after reset", win + lose, 0);
    m_done = 0; m_win = 0; m_lose = 0; m_later = 0; m_point = 0;
    pend = 1'b0; btn_prev = 1'b0; mon_skip = 1'b0;
    roll(5, 6, 2, "R10 new game uses first-roll rules");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule